// File: doc/BRIEF.md
# Stepped Trigger Delay Sequencer

The sequencer produces one trigger pulse per synchronization period for an equivalent-time sampling front end. It divides the fast reference clock down to a low-rate synchronization pulse. It then delays each trigger from that pulse by an amount that grows by a programmable step every time a trigger is issued. The delay is counted in units of 5 ps. Each delay value is split into two parts. The whole reference-clock periods are counted out in logic. The remainder is shifted out as a code to an external programmable delay element over a three-wire clock/data/latch port. That code is always latched before the coarse count runs out.

When the coarse part is too short to hide the serial write, the write is done in the current period and the trigger moves to the following one. The delay is reset to zero by the start control. It wraps back to zero when the next step would reach the configured range. The stop control lets the cycle in flight finish and then parks the block.

Controller states:
- `SQ_IDLE`: parked, no triggers.
- `SQ_ARM`: waiting for a synchronization pulse.
- `SQ_HOLD`: the fine code has been written and the block waits for the next synchronization pulse.
- `SQ_DELAY`: coarse count running.
- `SQ_PULSE`: trigger high.

Controller transitions:
- `SQ_IDLE` goes to `SQ_ARM` on start.
- `SQ_ARM` goes to `SQ_DELAY` on sync when the coarse count is at least the write time. It goes to `SQ_HOLD` on sync otherwise.
- `SQ_ARM` goes to `SQ_IDLE` on stop.
- `SQ_HOLD` goes to `SQ_DELAY` on sync.
- `SQ_DELAY` goes to `SQ_PULSE` when the count reaches zero.
- `SQ_PULSE` goes to `SQ_ARM`, or to `SQ_IDLE` if a stop is pending, after the pulse width.
- Start from any state returns to `SQ_ARM`.

Serial writer states:
- `SR_IDLE`: no write in progress.
- `SR_SETUP`: data bit presented with the serial clock low.
- `SR_HIGH`: serial clock high.
- `SR_LATCH`: latch strobe high.

Serial writer transitions:
- Load moves the writer to `SR_SETUP`.
- `SR_SETUP` goes to `SR_HIGH`.
- `SR_HIGH` goes back to `SR_SETUP` while bits remain, and to `SR_LATCH` after the last bit.
- `SR_LATCH` goes to `SR_IDLE`.

Top module: `tdl_seq`

## Requirements
- R1: `sync_o` is high for exactly one cycle every `div_period_i` cycles (`div_period_i` ≥ 2) and runs freely from reset.
- R2: For a delay value d, `trig_o` rises exactly `d / CLK_UNITS + 2` cycles after the cycle in which `sync_o` was high for the firing period.
- R3: The fine code `d % CLK_UNITS` is sent on `ser_dat_o` as FINE_W bits, most significant bit first. Each bit is valid when `ser_clk_o` rises. One cycle of `ser_le_o` follows the last bit. The latch comes before the trigger rises.
- R4: The first delay after start is zero. Each following trigger uses the previous delay plus `step_i`. When that sum is at least RANGE_UNITS, the delay becomes zero instead.
- R5: If the coarse count `d / CLK_UNITS` is below 2*FINE_W+1, the trigger is issued in the sync period after the one in which the code was written. Such a trigger comes two sync pulses after the previous trigger. Otherwise it comes one sync pulse after.
- R6: Every trigger is high for exactly PULSE_W cycles, and at most one trigger is issued per sync period.
- R7: A start pulse returns the delay and `idx_o` to zero from any state, and the next trigger uses delay zero.
- R8: After a stop pulse, the trigger of the cycle in progress is still issued, then `trig_o` stays low until the next start.
- R9: While a trigger is high, `idx_o` equals the number of triggers issued since start or since the last delay wrap, counting from zero.
- R10: After reset, `trig_o`, `ser_clk_o`, `ser_le_o` and `idx_o` are zero and no trigger is issued before a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the PLL |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Restart the delay ramp from zero |
| stop_i | input | 1 | Finish the current cycle, then park |
| step_i | input | DLY_W | Delay increment per trigger, 5 ps units |
| div_period_i | input | DIV_W | Sync period in clock cycles |
| sync_o | output | 1 | Synchronization pulse |
| trig_o | output | 1 | Delayed trigger pulse |
| ser_clk_o | output | 1 | Serial clock to the fine delay element |
| ser_dat_o | output | 1 | Serial data, MSB first |
| ser_le_o | output | 1 | Latch strobe to the fine delay element |
| idx_o | output | IDX_W | Index of the current delay step |

## Verification
The assertions check the following on every cycle:
- the single-cycle sync pulse;
- data stability at each serial clock rise;
- a one-cycle latch strobe;
- the fine writer being idle whenever a trigger starts;
- at most one trigger per sync period;
- the delay staying inside its range;
- the index clearing after start.

The cycle distance from sync to trigger, the decoded fine code, the exact wrap point, deferral into the next period, and the stop and restart behaviour can only be shown by the bench's scenarios. The bench sweeps the step size through 1, 7, 13, 0 and the largest legal value on a small configuration, and rebuilds every delay from the measured cycle count and the latched code.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_HOLD,
        SQ_DELAY,
        SQ_PULSE
    } seq_state_t;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_SETUP,
        SR_HIGH,
        SR_LATCH
    } ser_state_t;

endpackage

// File: rtl/tdl_sync_div.sv
module tdl_sync_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_period_i,
    output logic             sync_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sync_o <= 1'b0;
        end else if (cnt_q >= div_period_i - 1'b1) begin
            cnt_q  <= '0;
            sync_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            sync_o <= 1'b0;
        end
    end

    // R1: the sync pulse never lasts two cycles
    p_sync_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

endmodule

// File: rtl/tdl_split.sv
module tdl_split #(
    parameter int CLK_UNITS = 800,
    parameter int DLY_W     = 18,
    parameter int FINE_W    = 10
) (
    input  logic [DLY_W-1:0]  dly_i,
    output logic [DLY_W-1:0]  coarse_o,
    output logic [FINE_W-1:0] fine_o
);

    always_comb begin
        coarse_o = dly_i / DLY_W'(CLK_UNITS);
        fine_o   = FINE_W'(dly_i % DLY_W'(CLK_UNITS));
    end

endmodule

// File: rtl/tdl_fine_ser.sv
module tdl_fine_ser
    import tdl_pkg::*;
#(
    parameter  int FINE_W = 10,
    localparam int BC_W   = $clog2(FINE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FINE_W-1:0] code_i,
    output logic              ser_clk_o,
    output logic              ser_dat_o,
    output logic              ser_le_o,
    output logic              busy_o
);

    ser_state_t        st_q, st_d;
    logic [FINE_W-1:0] sh_q;
    logic [BC_W-1:0]   bits_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d = SR_SETUP;
        end else begin
            unique case (st_q)
                SR_IDLE:  st_d = SR_IDLE;
                SR_SETUP: st_d = SR_HIGH;
                SR_HIGH:  st_d = (bits_q == '0) ? SR_LATCH : SR_SETUP;
                SR_LATCH: st_d = SR_IDLE;
                default:  st_d = SR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bits_q <= '0;
        end else if (load_i) begin
            sh_q   <= code_i;
            bits_q <= BC_W'(FINE_W - 1);
        end else if (st_q == SR_HIGH && bits_q != '0) begin
            sh_q   <= sh_q << 1;
            bits_q <= bits_q - 1'b1;
        end
    end

    always_comb begin
        ser_clk_o = (st_q == SR_HIGH);
        ser_dat_o = (st_q == SR_SETUP || st_q == SR_HIGH) ? sh_q[FINE_W-1] : 1'b0;
        ser_le_o  = (st_q == SR_LATCH);
        busy_o    = (st_q != SR_IDLE);
    end

    // R3: data does not move while the serial clock rises
    p_dat_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $stable(ser_dat_o));

    // R3: latch strobe is a single cycle
    p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le_o |=> !ser_le_o);

endmodule

// File: rtl/tdl_seq.sv
module tdl_seq
    import tdl_pkg::*;
#(
    parameter  int CLK_UNITS   = 800,
    parameter  int RANGE_UNITS = 200000,
    parameter  int DIV_W       = 16,
    parameter  int IDX_W       = 16,
    parameter  int PULSE_W     = 1,
    localparam int FINE_W      = $clog2(CLK_UNITS),
    localparam int DLY_W       = $clog2(RANGE_UNITS + 1),
    localparam int LOAD_CYC    = 2 * FINE_W + 1,
    localparam int PC_W        = $clog2(PULSE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DLY_W-1:0] step_i,
    input  logic [DIV_W-1:0] div_period_i,
    output logic             sync_o,
    output logic             trig_o,
    output logic             ser_clk_o,
    output logic             ser_dat_o,
    output logic             ser_le_o,
    output logic [IDX_W-1:0] idx_o
);

    seq_state_t        state_q, state_d;
    logic [DLY_W-1:0]  dly_q;
    logic [DLY_W-1:0]  cnt_q;
    logic [PC_W-1:0]   pcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              stop_pend_q;
    logic [DLY_W-1:0]  coarse;
    logic [FINE_W-1:0] fine;
    logic [DLY_W:0]    sum;
    logic              wrap;
    logic              defer;
    logic              pulse_end;
    logic              ser_load;
    logic              ser_busy;

    tdl_sync_div #(.DIV_W(DIV_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_period_i (div_period_i),
        .sync_o       (sync_o)
    );

    tdl_split #(.CLK_UNITS(CLK_UNITS), .DLY_W(DLY_W), .FINE_W(FINE_W)) u_split (
        .dly_i    (dly_q),
        .coarse_o (coarse),
        .fine_o   (fine)
    );

    tdl_fine_ser #(.FINE_W(FINE_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ser_load),
        .code_i    (fine),
        .ser_clk_o (ser_clk_o),
        .ser_dat_o (ser_dat_o),
        .ser_le_o  (ser_le_o),
        .busy_o    (ser_busy)
    );

    always_comb begin
        sum       = {1'b0, dly_q} + {1'b0, step_i};
        wrap      = (sum >= (DLY_W + 1)'(RANGE_UNITS));
        defer     = (coarse < DLY_W'(LOAD_CYC));
        pulse_end = (pcnt_q == PC_W'(PULSE_W - 1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = SQ_ARM;
        end else begin
            unique case (state_q)
                SQ_IDLE:  state_d = SQ_IDLE;
                SQ_ARM: begin
                    if (stop_i)      state_d = SQ_IDLE;
                    else if (sync_o) state_d = defer ? SQ_HOLD : SQ_DELAY;
                end
                SQ_HOLD:  if (sync_o) state_d = SQ_DELAY;
                SQ_DELAY: if (cnt_q == '0) state_d = SQ_PULSE;
                SQ_PULSE: begin
                    if (pulse_end) state_d = (stop_pend_q || stop_i) ? SQ_IDLE : SQ_ARM;
                end
                default:  state_d = SQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // delay ramp, coarse counter and pulse width counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q       <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            pcnt_q      <= '0;
            stop_pend_q <= 1'b0;
        end else if (start_i) begin
            dly_q       <= '0;
            idx_q       <= '0;
            pcnt_q      <= '0;
            stop_pend_q <= 1'b0;
        end else begin
            stop_pend_q <= (stop_pend_q || stop_i) && (state_d != SQ_IDLE);
            if ((state_q == SQ_ARM || state_q == SQ_HOLD) && sync_o)
                cnt_q <= coarse;
            else if (state_q == SQ_DELAY && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (state_q == SQ_PULSE) begin
                pcnt_q <= pcnt_q + 1'b1;
                if (pulse_end) begin
                    dly_q <= wrap ? '0 : sum[DLY_W-1:0];
                    idx_q <= wrap ? '0 : idx_q + 1'b1;
                end
            end else begin
                pcnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        trig_o   = (state_q == SQ_PULSE);
        ser_load = (state_q == SQ_ARM) && sync_o && !start_i && !stop_i;
        idx_o    = idx_q;
    end

    logic fired_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                fired_q <= 1'b0;
        else if (sync_o)           fired_q <= 1'b0;
        else if (state_q == SQ_PULSE) fired_q <= 1'b1;
    end

    // R3: fine code is fully latched when the trigger starts
    p_fine_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> !ser_busy);

    // R6: no second trigger inside one sync period
    p_one_per_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DELAY && state_d == SQ_PULSE) |-> !fired_q);

    // R4: the ramp never leaves its range
    p_dly_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q < DLY_W'(RANGE_UNITS));

    // R7: start clears the step index
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (idx_o == '0));

endmodule

// File: tb/tdl_seq_tb.sv
`timescale 1ns/1ps
module tdl_seq_tb;

    localparam int CU    = 8;
    localparam int RANGE = 200;
    localparam int PW    = 2;
    localparam int FW    = 3;
    localparam int LOADC = 2 * FW + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] step_i = 8'd7;
    logic [7:0] div_period_i = 8'd40;
    logic       sync_o, trig_o, ser_clk_o, ser_dat_o, ser_le_o;
    logic [7:0] idx_o;

    tdl_seq #(.CLK_UNITS(CU), .RANGE_UNITS(RANGE), .DIV_W(8), .IDX_W(8), .PULSE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .step_i(step_i), .div_period_i(div_period_i), .sync_o(sync_o),
        .trig_o(trig_o), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
        .ser_le_o(ser_le_o), .idx_o(idx_o)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int div_v = 40, step_v = 7;
    bit div_skip = 1'b1;
    int last_sync = -1, syncs_since = 0;
    int exp_d = 0, exp_k = 0;
    int shreg = 0, nbits = 0, latch_code = -1, latch_cyc = -1;
    bit latch_seen = 1'b0;
    bit prev_clk = 1'b0, prev_trig = 1'b0;
    int width = 0, trig_total = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_o) begin
                if (last_sync >= 0 && !div_skip)
                    chk(cyc - last_sync == div_v, "R1 sync spacing", cyc - last_sync, div_v);
                div_skip    = 1'b0;
                last_sync   = cyc;
                syncs_since++;
            end
            if (ser_clk_o && !prev_clk) begin
                shreg = ((shreg << 1) | int'(ser_dat_o)) & 7;
                nbits++;
            end
            if (ser_le_o) begin
                chk(nbits == FW, "R3 bit count", nbits, FW);
                latch_code = shreg;
                latch_cyc  = cyc;
                latch_seen = 1'b1;
                nbits      = 0;
            end
            if (trig_o && !prev_trig) begin
                int c, f, dm;
                c  = exp_d / CU;
                f  = exp_d % CU;
                dm = (cyc - last_sync - 2) * CU + latch_code;
                chk(cyc - last_sync == c + 2, "R2 sync-to-trigger", cyc - last_sync, c + 2);
                chk(latch_seen && latch_code == f, "R3 fine code", latch_code, f);
                chk(latch_cyc < cyc, "R3 latch before trigger", latch_cyc, cyc);
                chk(dm == exp_d, "R4 rebuilt delay", dm, exp_d);
                chk(syncs_since == ((c < LOADC) ? 2 : 1), "R5 sync periods", syncs_since,
                    (c < LOADC) ? 2 : 1);
                chk(int'(idx_o) == exp_k, "R9 step index", idx_o, exp_k);
                if (exp_d + step_v >= RANGE) begin
                    exp_d = 0;
                    exp_k = 0;
                end else begin
                    exp_d += step_v;
                    exp_k++;
                end
                syncs_since = 0;
                latch_seen  = 1'b0;
                trig_total++;
                width = 1;
            end else if (trig_o) begin
                width++;
            end else if (prev_trig) begin
                chk(width == PW, "R6 pulse width", width, PW);
            end
            prev_clk  = ser_clk_o;
            prev_trig = trig_o;
        end
    end

    task automatic wait_sync();
        @(negedge clk);
        while (!sync_o) @(negedge clk);
    endtask

    task automatic start_run(input int stp, input int dv);
        wait_sync();
        @(posedge clk); #1;
        start_i      = 1'b1;
        step_i       = 8'(stp);
        step_v       = stp;
        if (dv != div_v) begin
            div_period_i = 8'(dv);
            div_v        = dv;
            div_skip     = 1'b1;
        end
        exp_d       = 0;
        exp_k       = 0;
        syncs_since = 0;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_trigs(input int n);
        int target;
        target = trig_total + n;
        while (trig_total < target) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", trig_total, -1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(trig_o == 1'b0, "R10 trig after reset", trig_o, 0);
        chk(idx_o == 8'd0, "R10 idx after reset", idx_o, 0);
        chk(ser_clk_o == 1'b0 && ser_le_o == 1'b0, "R10 serial idle", ser_le_o, 0);
        repeat (100) @(negedge clk);
        chk(trig_total == 0, "R10 no trigger before start", trig_total, 0);

        // R4 wrap with step 7, then R7 restart mid-run with step 13
        start_run(7, 40);
        wait_trigs(32);
        start_run(13, 40);
        @(negedge clk);
        chk(idx_o == 8'd0, "R7 index cleared", idx_o, 0);
        wait_trigs(20);

        // near-exhaustive sweep of every delay value, new divider period
        start_run(1, 45);
        wait_trigs(202);

        // zero step and largest step
        start_run(0, 45);
        wait_trigs(4);
        start_run(199, 45);
        wait_trigs(5);

        // R8 stop during a cycle in flight
        start_run(7, 45);
        wait_trigs(3);
        wait_sync();
        @(posedge clk); #1 stop_i = 1'b1;
        @(posedge clk); #1 stop_i = 1'b0;
        begin
            int base;
            base = trig_total;
            repeat (6 * 45) @(negedge clk);
            chk(trig_total == base + 1, "R8 only the pending trigger", trig_total, base + 1);
            chk(trig_o == 1'b0, "R8 output parked", trig_o, 0);
            chk(idx_o == 8'd4, "R9 index after stop", idx_o, 4);
        end

        // R7 restart after stop
        start_run(7, 45);
        wait_trigs(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule